// File: doc/BRIEF.md
# Word-Packed Serial Receiver with Idle Timeout

This block takes an asynchronous serial line carrying 8-N-1 characters, recovers each character by sampling at the middle of every bit, and gathers the characters into 32-bit words held in a small receive FIFO. Software reads the FIFO one word at a time. Characters are collected in transfers. A transfer starts when software writes an expected character count, and it ends on one of two conditions. The first is that the count is reached. The second is that the line stays quiet for a programmed number of character times after the last good character.

When a transfer ends, any partly built word goes into the FIFO with its unused upper bytes set to zero. A snapshot register then holds the number of valid characters in that transfer, so software knows how many bytes of the last word to use. The idle timeout can be turned on and off by command pulses, and its interrupt flag has its own clear command. A lost word (FIFO full), a bad stop bit and a FIFO fill level at or above a watermark are all reported on flags.

Top module: `uart_word_rx`

## Requirements
- R1: Four characters go into each FIFO word, with the earliest character in bits 7:0 and the latest in bits 31:24. A word is pushed as soon as its fourth character is received.
- R2: Once the number of characters received since `xfer_len_wr` equals `xfer_len`, the transfer ends and `xfer_end` pulses for one cycle. A partial word (1 to 3 bytes) is pushed with its upper bytes set to zero.
- R3: At every transfer end, `snap_count` takes the number of valid characters received in that transfer and holds it until the next end.
- R4: If the idle timeout is enabled and at least one character has arrived in the active transfer, then `stale_limit` character times (10 bit periods each) of idle line end the transfer. `stale_irq` is set and the partial word is flushed. With no characters received, the timeout never fires.
- R5: `cmd_stale_off` stops the idle timeout and `cmd_stale_on` restarts it; while it is off, the idle time causes no flush and no end. `cmd_stale_ack` clears `stale_irq`.
- R6: `rx_ready` is high exactly when the FIFO holds at least one word. `fifo_level` gives the word count.
- R7: A word completed while the FIFO is full is thrown away and sets the sticky `overrun` flag. The words already stored are kept. `cmd_err_clr` clears the flag.
- R8: A character whose stop bit samples low is not stored and not counted. It sets the sticky `frame_err` flag, which `cmd_err_clr` clears.
- R9: `wmark_irq` is high while `rx_wmark` is nonzero and `fifo_level` is at least `rx_wmark`.
- R10: Characters that arrive while no transfer is active are dropped and leave the FIFO unchanged.
- R11: After reset the FIFO is empty, no transfer is active, all flags are low and `snap_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| xfer_len_wr | input | 1 | Pulse: start a transfer with `xfer_len` |
| xfer_len | input | CNT_W | Expected character count |
| stale_limit | input | STALE_W | Idle character times before timeout (0 disables) |
| rx_wmark | input | FIFO_AW+1 | FIFO level watermark |
| cmd_stale_on | input | 1 | Pulse: enable idle timeout |
| cmd_stale_off | input | 1 | Pulse: disable idle timeout |
| cmd_stale_ack | input | 1 | Pulse: clear `stale_irq` |
| cmd_err_clr | input | 1 | Pulse: clear `overrun` and `frame_err` |
| cmd_rx_flush | input | 1 | Pulse: empty FIFO and abort transfer |
| rd_en | input | 1 | Pop one word; data valid next cycle |
| rd_data | output | 32 | Popped word |
| rx_ready | output | 1 | FIFO not empty |
| fifo_level | output | FIFO_AW+1 | Words in FIFO |
| wmark_irq | output | 1 | Level at or above watermark |
| stale_irq | output | 1 | Idle timeout occurred |
| xfer_end | output | 1 | One-cycle pulse at transfer end |
| snap_count | output | CNT_W | Characters in last transfer |
| overrun | output | 1 | Word lost to full FIFO |
| frame_err | output | 1 | Bad stop bit seen |

## Verification
A six-character transfer tests the lane order together with the zero padding at a count end. Three characters followed by silence test the timeout flush. Its timing is bounded from both sides to separate a correct idle count from one that is off by a whole character. An idle period with no characters, and another with the timeout switched off, show that only an armed and enabled timer can end a transfer. A low stop bit placed in the middle of a count-ended transfer tests exclusion from both data and count. A burst of twenty characters into a four-word FIFO tests the watermark crossing, the loss of the fifth word and the survival of the first four.

// File: rtl/uart_word_rx_pkg.sv
package uart_word_rx_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_e;
  localparam int WORD_W = 32;
  localparam int BITS_PER_CHAR = 10;
endpackage

// File: rtl/uwrx_framer.sv
module uwrx_framer
  import uart_word_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  output logic       chr_valid,
  output logic [7:0] chr_data,
  output logic       chr_bad,
  output logic       busy
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

  logic [1:0]    sync;
  fr_state_e     st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;

  assign busy = (st != FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11; st <= FR_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      chr_valid <= 1'b0; chr_bad <= 1'b0; chr_data <= '0;
    end else begin
      sync <= {sync[0], rxd};
      chr_valid <= 1'b0;
      chr_bad <= 1'b0;
      case (st)
        FR_IDLE: begin
          cnt <= '0;
          if (!sync[1]) st <= FR_START;
        end
        FR_START: begin
          if (cnt == HALF) begin
            cnt <= '0; bitn <= '0;
            st <= sync[1] ? FR_IDLE : FR_DATA;
          end else cnt <= cnt + 1'b1;
        end
        FR_DATA: begin
          if (cnt == FULL) begin
            cnt <= '0;
            shreg <= {sync[1], shreg[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= FR_STOP;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == FULL) begin
            cnt <= '0;
            st <= FR_IDLE;
            if (sync[1]) begin
              chr_valid <= 1'b1; chr_data <= shreg;
            end else chr_bad <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  p_good_or_bad_r8: assert property (@(posedge clk) disable iff (rst)
    !(chr_valid && chr_bad));
  p_report_from_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (chr_valid || chr_bad) |-> $past(st) == FR_STOP);
endmodule

// File: rtl/uwrx_fifo.sv
module uwrx_fifo #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [AW:0]   level,
  output logic          drop
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_w, do_r;

  assign full = (level == (AW+1)'(DEPTH));
  assign do_w = push && !full;
  assign do_r = pop && (level != '0);
  assign drop = push && full;

  always_ff @(posedge clk) begin
    if (do_w) mem[wp] <= push_data;
    if (do_r) pop_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_w) wp <= wp + 1'b1;
      if (do_r) rp <= rp + 1'b1;
      case ({do_w, do_r})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));
  p_drop_keeps_full_r7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> level == (AW+1)'(DEPTH));
endmodule

// File: rtl/uwrx_xfer.sv
module uwrx_xfer #(
  parameter int CNT_W     = 16,
  parameter int STALE_W   = 8,
  parameter int CHAR_CLKS = 160
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               abort,
  input  logic               chr_valid,
  input  logic [7:0]         chr_data,
  input  logic               line_busy,
  input  logic               len_wr,
  input  logic [CNT_W-1:0]   len_val,
  input  logic [STALE_W-1:0] stale_lim,
  input  logic               stale_on,
  input  logic               stale_off,
  input  logic               stale_ack,
  output logic               push,
  output logic [31:0]        push_data,
  output logic               xfer_end,
  output logic [CNT_W-1:0]   snap,
  output logic               stale_irq
);
  localparam int TW = $clog2(CHAR_CLKS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(CHAR_CLKS - 1);

  logic               active, stale_en;
  logic [1:0]         lane;
  logic [31:0]        pack, next_pack;
  logic [CNT_W-1:0]   rcount, len_q;
  logic [TW-1:0]      tick;
  logic [STALE_W-1:0] chars;
  logic               last, armed, stale_hit;

  always_comb begin
    next_pack = pack;
    next_pack[{lane, 3'b000} +: 8] = chr_data;
  end
  assign last      = (rcount + 1'b1) == len_q;
  assign armed     = active && stale_en && (rcount != '0) && !line_busy && !chr_valid;
  assign stale_hit = (tick == TICK_LAST) &&
                     (({1'b0, chars} + 1'b1) == {1'b0, stale_lim});

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0; stale_en <= 1'b1; lane <= '0; pack <= '0;
      rcount <= '0; len_q <= '0; tick <= '0; chars <= '0;
      push <= 1'b0; push_data <= '0; xfer_end <= 1'b0; snap <= '0; stale_irq <= 1'b0;
    end else begin
      push <= 1'b0;
      xfer_end <= 1'b0;
      if (stale_on)  stale_en <= 1'b1;
      if (stale_off) stale_en <= 1'b0;
      if (stale_ack) stale_irq <= 1'b0;
      if (len_wr) begin
        active <= 1'b1; len_q <= len_val; rcount <= '0;
        lane <= '0; pack <= '0; tick <= '0; chars <= '0;
      end else if (active && chr_valid) begin
        rcount <= rcount + 1'b1;
        tick <= '0; chars <= '0;
        if (lane == 2'd3 || last) begin
          push <= 1'b1; push_data <= next_pack; pack <= '0; lane <= '0;
        end else begin
          pack <= next_pack; lane <= lane + 1'b1;
        end
        if (last) begin
          active <= 1'b0; xfer_end <= 1'b1; snap <= rcount + 1'b1;
        end
      end else if (armed) begin
        if (tick == TICK_LAST) begin
          tick <= '0;
          chars <= chars + 1'b1;
          if (stale_hit) begin
            stale_irq <= 1'b1; active <= 1'b0; xfer_end <= 1'b1; snap <= rcount;
            if (lane != '0) begin
              push <= 1'b1; push_data <= pack; pack <= '0; lane <= '0;
            end
          end
        end else tick <= tick + 1'b1;
      end else begin
        tick <= '0; chars <= '0;
      end
    end
  end

  p_count_end_r2: assert property (@(posedge clk) disable iff (rst || abort)
    (active && chr_valid && !len_wr && last) |=> (xfer_end && !active));
  p_stale_needs_char_r4: assert property (@(posedge clk) disable iff (rst || abort)
    ($rose(stale_irq) && $past(!len_wr)) |-> $past(rcount) != '0);
  p_end_closes_r3: assert property (@(posedge clk) disable iff (rst || abort)
    xfer_end |-> !active);
endmodule

// File: rtl/uart_word_rx.sv
module uart_word_rx
  import uart_word_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FIFO_AW      = 4,
  parameter int CNT_W        = 16,
  parameter int STALE_W      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxd,
  input  logic               xfer_len_wr,
  input  logic [CNT_W-1:0]   xfer_len,
  input  logic [STALE_W-1:0] stale_limit,
  input  logic [FIFO_AW:0]   rx_wmark,
  input  logic               cmd_stale_on,
  input  logic               cmd_stale_off,
  input  logic               cmd_stale_ack,
  input  logic               cmd_err_clr,
  input  logic               cmd_rx_flush,
  input  logic               rd_en,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rx_ready,
  output logic [FIFO_AW:0]   fifo_level,
  output logic               wmark_irq,
  output logic               stale_irq,
  output logic               xfer_end,
  output logic [CNT_W-1:0]   snap_count,
  output logic               overrun,
  output logic               frame_err
);
  localparam int CHAR_CLKS = BITS_PER_CHAR * CLKS_PER_BIT;

  logic              chr_valid, chr_bad, line_busy, push, drop;
  logic [7:0]        chr_data;
  logic [WORD_W-1:0] push_data;

  uwrx_framer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_framer (
    .clk(clk), .rst(rst), .rxd(rxd), .chr_valid(chr_valid),
    .chr_data(chr_data), .chr_bad(chr_bad), .busy(line_busy));

  uwrx_xfer #(.CNT_W(CNT_W), .STALE_W(STALE_W), .CHAR_CLKS(CHAR_CLKS)) u_xfer (
    .clk(clk), .rst(rst), .abort(cmd_rx_flush), .chr_valid(chr_valid),
    .chr_data(chr_data), .line_busy(line_busy), .len_wr(xfer_len_wr),
    .len_val(xfer_len), .stale_lim(stale_limit), .stale_on(cmd_stale_on),
    .stale_off(cmd_stale_off), .stale_ack(cmd_stale_ack), .push(push),
    .push_data(push_data), .xfer_end(xfer_end), .snap(snap_count),
    .stale_irq(stale_irq));

  uwrx_fifo #(.AW(FIFO_AW), .DW(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(cmd_rx_flush), .push(push),
    .push_data(push_data), .pop(rd_en), .pop_data(rd_data),
    .level(fifo_level), .drop(drop));

  assign rx_ready = (fifo_level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0; frame_err <= 1'b0; wmark_irq <= 1'b0;
    end else begin
      if (cmd_err_clr) begin overrun <= 1'b0; frame_err <= 1'b0; end
      if (drop)    overrun <= 1'b1;
      if (chr_bad) frame_err <= 1'b1;
      wmark_irq <= (rx_wmark != '0) && (fifo_level >= rx_wmark);
    end
  end

  p_drop_flags_r7: assert property (@(posedge clk) disable iff (rst)
    drop |=> overrun);
  p_bad_stop_flags_r8: assert property (@(posedge clk) disable iff (rst)
    chr_bad |=> frame_err);
  p_bad_not_pushed_r8: assert property (@(posedge clk) disable iff (rst)
    (chr_bad && !push) |=> !push);
endmodule

// File: tb/uart_word_rx_test.sv
`timescale 1ns/1ps
module uart_word_rx_test;
  localparam int CPB = 16;
  localparam int AW = 2;
  localparam int CH = 10 * CPB;

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1;
  logic xfer_len_wr = 0, cmd_stale_on = 0, cmd_stale_off = 0, cmd_stale_ack = 0;
  logic cmd_err_clr = 0, cmd_rx_flush = 0, rd_en = 0;
  logic [15:0] xfer_len = '0;
  logic [7:0]  stale_limit = 8'd3;
  logic [AW:0] rx_wmark = '0;
  logic [31:0] rd_data;
  logic rx_ready, wmark_irq, stale_irq, xfer_end, overrun, frame_err;
  logic [AW:0] fifo_level;
  logic [15:0] snap_count;
  int total = 0, bad = 0, ends = 0;

  always #5 clk = ~clk;

  uart_word_rx #(.CLKS_PER_BIT(CPB), .FIFO_AW(AW)) uut (
    .clk(clk), .rst(rst), .rxd(rxd), .xfer_len_wr(xfer_len_wr), .xfer_len(xfer_len),
    .stale_limit(stale_limit), .rx_wmark(rx_wmark), .cmd_stale_on(cmd_stale_on),
    .cmd_stale_off(cmd_stale_off), .cmd_stale_ack(cmd_stale_ack),
    .cmd_err_clr(cmd_err_clr), .cmd_rx_flush(cmd_rx_flush), .rd_en(rd_en),
    .rd_data(rd_data), .rx_ready(rx_ready), .fifo_level(fifo_level),
    .wmark_irq(wmark_irq), .stale_irq(stale_irq), .xfer_end(xfer_end),
    .snap_count(snap_count), .overrun(overrun), .frame_err(frame_err));

  always @(negedge clk) if (!rst && xfer_end) ends++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit good = 1'b1);
    rxd = 1'b0; wait_clk(CPB);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_clk(CPB); end
    if (good) begin rxd = 1'b1; wait_clk(CPB); end
    else begin rxd = 1'b0; wait_clk(CPB/2 + 4); rxd = 1'b1; wait_clk(CH); end
  endtask

  task automatic start_xfer(input logic [15:0] n);
    xfer_len = n; xfer_len_wr = 1'b1; wait_clk(1); xfer_len_wr = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wait_clk(1); s = 1'b0;
  endtask

  task automatic read_word(input string req, input logic [31:0] exp);
    rd_en = 1'b1; wait_clk(1); rd_en = 1'b0;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic t_reset;
    chk(fifo_level == 0 && !rx_ready, "R11 level", 32'(fifo_level), 0);
    chk(!overrun && !frame_err && !stale_irq && !wmark_irq && !xfer_end, "R11 flags",
        {overrun, frame_err, stale_irq, wmark_irq, xfer_end}, 0);
    chk(snap_count == 0, "R11 snap", 32'(snap_count), 0);
  endtask

  task automatic t_count_end;
    int e0 = ends;
    start_xfer(16'd6);
    chk(!rx_ready, "R6 empty before", 32'(rx_ready), 0);
    send(8'h11); send(8'h22); send(8'h33);
    wait_clk(4);
    chk(!rx_ready, "R1 no word before fourth", 32'(fifo_level), 0);
    send(8'h44); wait_clk(4);
    chk(rx_ready && fifo_level == 1, "R6 ready after word", 32'(fifo_level), 1);
    send(8'h55); send(8'h66); wait_clk(4);
    chk(ends == e0 + 1, "R2 one end pulse", ends - e0, 1);
    chk(snap_count == 6, "R3 snap count", 32'(snap_count), 6);
    chk(fifo_level == 2, "R2 partial pushed", 32'(fifo_level), 2);
    read_word("R1 lane order", 32'h44332211);
    read_word("R2 zero padded", 32'h00006655);
    chk(!rx_ready, "R6 empty after reads", 32'(rx_ready), 0);
  endtask

  task automatic t_stale;
    start_xfer(16'd100);
    send(8'hA1); send(8'hA2); send(8'hA3);
    wait_clk(3 * CH - 2 * CPB);
    chk(!stale_irq, "R4 not early", 32'(stale_irq), 0);
    wait_clk(3 * CPB);
    chk(stale_irq, "R4 timeout fires", 32'(stale_irq), 1);
    chk(snap_count == 3, "R3 snap on stale", 32'(snap_count), 3);
    read_word("R4 flushed partial", 32'h00A3A2A1);
    pulse(cmd_stale_ack); wait_clk(1);
    chk(!stale_irq, "R5 ack clears", 32'(stale_irq), 0);
  endtask

  task automatic t_stale_gate;
    start_xfer(16'd100);
    wait_clk(5 * CH);
    chk(!stale_irq, "R4 not armed with no chars", 32'(stale_irq), 0);
    pulse(cmd_stale_off);
    send(8'h7E);
    wait_clk(5 * CH);
    chk(!stale_irq && fifo_level == 0, "R5 off holds", {stale_irq, 28'd0, fifo_level}, 0);
    pulse(cmd_stale_on);
    wait_clk(3 * CH + 40);
    chk(stale_irq, "R5 on re-arms", 32'(stale_irq), 1);
    chk(snap_count == 1, "R3 snap one", 32'(snap_count), 1);
    read_word("R4 single byte word", 32'h0000007E);
    pulse(cmd_stale_ack);
  endtask

  task automatic t_frame;
    start_xfer(16'd2);
    send(8'h5A, 1'b0);
    wait_clk(2);
    chk(frame_err, "R8 flag set", 32'(frame_err), 1);
    send(8'h01); send(8'h02); wait_clk(4);
    chk(snap_count == 2, "R8 bad char not counted", 32'(snap_count), 2);
    read_word("R8 bad char not stored", 32'h00000201);
    pulse(cmd_err_clr); wait_clk(1);
    chk(!frame_err, "R8 clear", 32'(frame_err), 0);
  endtask

  task automatic t_idle_drop;
    int e0 = ends;
    send(8'h33); wait_clk(4 * CH);
    chk(fifo_level == 0 && ends == e0, "R10 dropped", 32'(fifo_level), 0);
  endtask

  task automatic t_overrun;
    rx_wmark = 3'd3;
    start_xfer(16'd20);
    for (int i = 0; i < 8; i++) send(8'(i));
    wait_clk(4);
    chk(!wmark_irq, "R9 below mark", 32'(wmark_irq), 0);
    for (int i = 8; i < 12; i++) send(8'(i));
    wait_clk(4);
    chk(wmark_irq, "R9 at mark", 32'(wmark_irq), 1);
    for (int i = 12; i < 20; i++) send(8'(i));
    wait_clk(4);
    chk(overrun, "R7 overrun set", 32'(overrun), 1);
    chk(fifo_level == 4, "R7 level full", 32'(fifo_level), 4);
    chk(snap_count == 20, "R3 snap twenty", 32'(snap_count), 20);
    read_word("R7 old word kept", 32'h03020100);
    read_word("R7 word2", 32'h07060504);
    read_word("R7 word3", 32'h0B0A0908);
    read_word("R7 word4", 32'h0F0E0D0C);
    chk(!rx_ready, "R7 fifth discarded", 32'(fifo_level), 0);
    pulse(cmd_err_clr); wait_clk(1);
    chk(!overrun, "R7 clear", 32'(overrun), 0);
  endtask

  initial begin
    wait_clk(4); rst = 1'b0; wait_clk(2);
    t_reset();
    t_count_end();
    t_stale();
    t_stale_gate();
    t_frame();
    t_idle_drop();
    t_overrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule